// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Interrupt Entry

This block is the multicycle control core of a small processor. It owns the program counter, the memory address and memory buffer registers, the instruction register and the stack pointer. It moves values between them in a fixed order of register transfers. Each instruction is fetched from memory over a simple request/ready interface. The block then hands control to an external datapath for execution and waits for that datapath to report completion.

When execution finishes, the sequencer checks the interrupt line. If an enabled request is pending, it runs an interrupt cycle. This cycle pushes the return address to a downward-growing stack in memory, clears the interrupt enable and redirects the program counter to a handler address. The next fetch then reads the handler's first instruction. Otherwise the next fetch starts at once. The datapath can also override the incremented program counter with a jump target when it signals completion.

Top module: `instr_cycle_seq`

## Requirements
- R1: While reset is held, PC equals RESET_PC, SP equals STACK_TOP, IE is 0, IR, MAR and MBR are 0, and neither memory strobe is active.
- R2: A fetch first copies PC into MAR, so mem_addr shows the fetch address one cycle after the fetch begins. mem_rd is then asserted with that address and held, unchanged, until mem_ready is seen.
- R3: On the clock where mem_rd and mem_ready are both high, mem_rdata is captured into MBR. On the next clock MBR is copied into IR, and exec_active then rises.
- R4: PC is incremented by exactly 1 on the clock that completes the instruction read.
- R5: exec_active stays high until exec_done is seen. If jump_valid is high on that clock, PC is loaded with jump_target instead of keeping its incremented value.
- R6: An interrupt is taken only when irq_req and IE are both 1 on the clock that execution completes. Otherwise the next clock begins a fetch, and mem_rd follows one cycle later.
- R7: On interrupt entry, SP is decremented by 1, MAR receives the new SP, MBR receives the current PC zero-extended to DW bits, and IE is cleared.
- R8: mem_wr is then asserted with mem_addr equal to SP and mem_wdata equal to the saved PC, held until mem_ready. On that clock PC is loaded with vec_addr, and the following fetch reads address vec_addr.
- R9: A pulse on ie_set makes IE 1 on the next clock. If it coincides with interrupt entry, the clear wins.
- R10: mem_rd and mem_wr are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_ready | input | 1 | Memory completes the current access |
| mem_rdata | input | DW | Read data from memory |
| irq_req | input | 1 | Interrupt request level |
| ie_set | input | 1 | Pulse that sets the interrupt enable |
| vec_addr | input | AW | Interrupt handler start address |
| exec_done | input | 1 | Datapath has finished executing IR |
| jump_valid | input | 1 | With exec_done, replace PC by jump_target |
| jump_target | input | AW | Jump destination |
| mem_addr | output | AW | Address bus (MAR) |
| mem_wdata | output | DW | Write data bus (MBR) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ld_mar | output | 1 | MAR loads this clock |
| ld_mbr | output | 1 | MBR loads this clock |
| ld_ir | output | 1 | IR loads this clock |
| ld_pc | output | 1 | PC loads this clock |
| exec_active | output | 1 | IR is being executed by the datapath |
| pc | output | AW | Program counter |
| ir | output | DW | Instruction register |
| sp | output | AW | Stack pointer |
| ie | output | 1 | Interrupt enable flag |

## Verification
The assertions check several properties on every cycle: the two strobes are mutually exclusive, address and data are held while memory stalls, PC steps by one on a read completion, and PC takes the vector on a write completion. They also check that IR receives the read word two clocks after the read, that a completed execute leads to a read or a write two clocks later depending on the gated request, and that IE clears after entry. Other behaviour can only be shown by the bench's scenarios: the return address actually lands in memory at the decremented stack slot, the handler's first word reaches IR, and a still-high request is not re-entered until enable is set again. Jump redirection, nested entries at successive stack slots, and behaviour under different memory and execute latencies are likewise covered by scenarios compared against the reference model.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    S_FADDR  = 3'd0,
    S_FREAD  = 3'd1,
    S_FIR    = 3'd2,
    S_EXEC   = 3'd3,
    S_ISAVE  = 3'd4,
    S_IWRITE = 3'd5
  } seq_state_t;

  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_sp;
    logic mbr_from_mem;
    logic mbr_from_pc;
    logic ir_from_mbr;
    logic pc_inc;
    logic pc_jump;
    logic pc_vec;
    logic sp_dec;
    logic ie_clr;
  } seq_ctl_t;
endpackage

// File: rtl/seq_fsm.sv
module seq_fsm
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mem_ready,
  input  logic       exec_done,
  input  logic       jump_valid,
  input  logic       take_irq,
  output seq_state_t state,
  output seq_ctl_t   ctl
);
  seq_state_t nxt;

  always_comb begin
    nxt = state;
    ctl = '0;
    unique case (state)
      S_FADDR: begin
        ctl.mar_from_pc = 1'b1;
        nxt = S_FREAD;
      end
      S_FREAD: if (mem_ready) begin
        ctl.mbr_from_mem = 1'b1;
        ctl.pc_inc       = 1'b1;
        nxt = S_FIR;
      end
      S_FIR: begin
        ctl.ir_from_mbr = 1'b1;
        nxt = S_EXEC;
      end
      S_EXEC: if (exec_done) begin
        ctl.pc_jump = jump_valid;
        nxt = take_irq ? S_ISAVE : S_FADDR;
      end
      S_ISAVE: begin
        ctl.mbr_from_pc = 1'b1;
        ctl.sp_dec      = 1'b1;
        ctl.mar_from_sp = 1'b1;
        ctl.ie_clr      = 1'b1;
        nxt = S_IWRITE;
      end
      S_IWRITE: if (mem_ready) begin
        ctl.pc_vec = 1'b1;
        nxt = S_FADDR;
      end
      default: nxt = S_FADDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_FADDR;
    else     state <= nxt;
  end
endmodule

// File: rtl/seq_regs.sv
module seq_regs
  import seq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter logic [AW-1:0] RESET_PC  = '0,
  parameter logic [AW-1:0] STACK_TOP = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_ctl_t      ctl,
  input  logic          ie_set,
  input  logic [DW-1:0] mem_rdata,
  input  logic [AW-1:0] vec_addr,
  input  logic [AW-1:0] jump_target,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] mar_q,
  output logic [DW-1:0] mbr_q,
  output logic [DW-1:0] ir_q,
  output logic [AW-1:0] sp_q,
  output logic          ie_q
);
  logic [AW-1:0] sp_dn;
  assign sp_dn = sp_q - AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= RESET_PC;
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
      sp_q  <= STACK_TOP;
      ie_q  <= 1'b0;
    end else begin
      if (ctl.mar_from_pc)       mar_q <= pc_q;
      else if (ctl.mar_from_sp)  mar_q <= sp_dn;
      if (ctl.mbr_from_mem)      mbr_q <= mem_rdata;
      else if (ctl.mbr_from_pc)  mbr_q <= DW'(pc_q);
      if (ctl.ir_from_mbr)       ir_q  <= mbr_q;
      if (ctl.pc_inc)            pc_q  <= pc_q + AW'(1);
      else if (ctl.pc_jump)      pc_q  <= jump_target;
      else if (ctl.pc_vec)       pc_q  <= vec_addr;
      if (ctl.sp_dec)            sp_q  <= sp_dn;
      if (ctl.ie_clr)            ie_q  <= 1'b0;
      else if (ie_set)           ie_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
  import seq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter logic [AW-1:0] RESET_PC  = '0,
  parameter logic [AW-1:0] STACK_TOP = 8'hF0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  input  logic          irq_req,
  input  logic          ie_set,
  input  logic [AW-1:0] vec_addr,
  input  logic          exec_done,
  input  logic          jump_valid,
  input  logic [AW-1:0] jump_target,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          ld_mar,
  output logic          ld_mbr,
  output logic          ld_ir,
  output logic          ld_pc,
  output logic          exec_active,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] ir,
  output logic [AW-1:0] sp,
  output logic          ie
);
  seq_state_t    state;
  seq_ctl_t      ctl;
  logic          take_irq;
  logic [AW-1:0] mar_q;
  logic [DW-1:0] mbr_q;

  assign take_irq = irq_req & ie;

  seq_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .mem_ready  (mem_ready),
    .exec_done  (exec_done),
    .jump_valid (jump_valid),
    .take_irq   (take_irq),
    .state      (state),
    .ctl        (ctl)
  );

  seq_regs #(
    .AW(AW), .DW(DW), .RESET_PC(RESET_PC), .STACK_TOP(STACK_TOP)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .ctl         (ctl),
    .ie_set      (ie_set),
    .mem_rdata   (mem_rdata),
    .vec_addr    (vec_addr),
    .jump_target (jump_target),
    .pc_q        (pc),
    .mar_q       (mar_q),
    .mbr_q       (mbr_q),
    .ir_q        (ir),
    .sp_q        (sp),
    .ie_q        (ie)
  );

  assign mem_addr    = mar_q;
  assign mem_wdata   = mbr_q;
  assign mem_rd      = (state == S_FREAD);
  assign mem_wr      = (state == S_IWRITE);
  assign exec_active = (state == S_EXEC);
  assign ld_mar      = ctl.mar_from_pc | ctl.mar_from_sp;
  assign ld_mbr      = ctl.mbr_from_mem | ctl.mbr_from_pc;
  assign ld_ir       = ctl.ir_from_mbr;
  assign ld_pc       = ctl.pc_inc | ctl.pc_jump | ctl.pc_vec;
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_ready,
  input logic [DW-1:0] mem_rdata,
  input logic          irq_req,
  input logic [AW-1:0] vec_addr,
  input logic          exec_done,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          exec_active,
  input logic [AW-1:0] pc,
  input logic [DW-1:0] ir,
  input logic [AW-1:0] sp,
  input logic          ie
);
  p_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (rst)
    mem_rd && !mem_ready |=> mem_rd && $stable(mem_addr));

  p_ir_load_r3: assert property (@(posedge clk) disable iff (rst)
    mem_rd && mem_ready |=> ##1 (ir == $past(mem_rdata, 2)) && exec_active);

  p_pc_inc_r4: assert property (@(posedge clk) disable iff (rst)
    mem_rd && mem_ready |=> pc == $past(pc) + AW'(1));

  p_no_irq_r6: assert property (@(posedge clk) disable iff (rst)
    exec_active && exec_done && !(irq_req && ie) |=> ##1 mem_rd);

  p_irq_r6: assert property (@(posedge clk) disable iff (rst)
    exec_active && exec_done && irq_req && ie |=> ##1 mem_wr);

  p_ie_clr_r7: assert property (@(posedge clk) disable iff (rst)
    exec_active && exec_done && irq_req && ie |=> ##1 !ie);

  p_sp_dec_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wr) |-> (sp == $past(sp) - AW'(1)) && (mem_addr == sp));

  p_wr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    mem_wr && !mem_ready |=> mem_wr && $stable(mem_addr) && $stable(mem_wdata));

  p_vec_r8: assert property (@(posedge clk) disable iff (rst)
    mem_wr && mem_ready |=> pc == $past(vec_addr));
endmodule

bind instr_cycle_seq seq_checker #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tb_instr_cycle_seq.sv
module tb_instr_cycle_seq;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam logic [AW-1:0] RPC = 8'h00;
  localparam logic [AW-1:0] STK = 8'hF0;
  localparam logic [AW-1:0] VEC = 8'h80;

  logic clk = 0, rst = 1;
  logic mem_ready = 0, irq_req = 0, ie_set = 0, exec_done = 0, jump_valid = 0;
  logic [DW-1:0] mem_rdata = '0;
  logic [AW-1:0] vec_addr = VEC, jump_target = 8'h40;
  logic [AW-1:0] mem_addr, pc, sp;
  logic [DW-1:0] mem_wdata, ir;
  logic mem_rd, mem_wr, ld_mar, ld_mbr, ld_ir, ld_pc, exec_active, ie;

  instr_cycle_seq #(.AW(AW), .DW(DW), .RESET_PC(RPC), .STACK_TOP(STK)) dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int mem_lat = 0, exec_lat = 0, mcnt = 0, ecnt = 0, wr_count = 0;
  logic do_jump = 0;
  logic [DW-1:0] mem [256];

  function automatic logic [DW-1:0] prog(input int a);
    return {8'hC3 ^ 8'(a), 8'(a)};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // behavioural reference model
  int m_st = 0;
  logic [AW-1:0] m_pc, m_mar, m_sp;
  logic [DW-1:0] m_mbr, m_ir;
  logic m_ie;
  logic [AW-1:0] ret_q[$];

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_pc = RPC; m_mar = '0; m_mbr = '0; m_ir = '0; m_sp = STK; m_ie = 0;
    end else begin
      logic set_ie;
      set_ie = ie_set;
      case (m_st)
        0: begin m_mar = m_pc; m_st = 1; end
        1: if (mem_ready) begin m_mbr = mem[m_mar]; m_pc = m_pc + 1; m_st = 2; end
        2: begin m_ir = m_mbr; m_st = 3; end
        3: if (exec_done) begin
             if (jump_valid) m_pc = jump_target;
             m_st = (irq_req && m_ie) ? 4 : 0;
           end
        4: begin
             m_mbr = DW'(m_pc); m_sp = m_sp - 1; m_mar = m_sp; m_ie = 0;
             set_ie = 0; ret_q.push_back(m_pc); m_st = 5;
           end
        default: if (mem_ready) begin m_pc = vec_addr; m_st = 0; end
      endcase
      if (set_ie) m_ie = 1;
    end
    if (!rst && mem_wr && mem_ready) begin
      mem[mem_addr] = mem_wdata;
      wr_count++;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R4/R5/R8", "pc", pc, m_pc);
      chk("R3", "ir", ir, m_ir);
      chk("R2/R7", "mem_addr", mem_addr, m_mar);
      chk("R7", "mem_wdata", mem_wdata, m_mbr);
      chk("R7", "sp", sp, m_sp);
      chk("R9", "ie", ie, m_ie);
      chk("R2", "mem_rd", mem_rd, m_st == 1);
      chk("R8", "mem_wr", mem_wr, m_st == 5);
      chk("R5", "exec_active", exec_active, m_st == 3);
      chk("R10", "strobes exclusive", mem_rd & mem_wr, 0);
    end
  end

  // memory and datapath responders
  always @(negedge clk) begin
    if (mem_rd || mem_wr) begin
      mcnt++;
      mem_ready = (mcnt > mem_lat);
      mem_rdata = mem[mem_addr];
    end else begin
      mcnt = 0; mem_ready = 0;
    end
    if (exec_active) begin
      ecnt++;
      exec_done  = (ecnt > exec_lat);
      jump_valid = exec_done & do_jump;
    end else begin
      if (jump_valid) do_jump = 0;
      ecnt = 0; exec_done = 0; jump_valid = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic pulse_ie();
    @(negedge clk); ie_set = 1;
    @(negedge clk); ie_set = 0;
  endtask

  task automatic wait_exec_rise();
    @(negedge clk);
    while (exec_active) @(negedge clk);
    while (!exec_active) @(negedge clk);
  endtask

  initial begin
    logic [AW-1:0] r;
    for (int i = 0; i < 256; i++) mem[i] = prog(i);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "pc", pc, RPC);
    chk("R1", "sp", sp, STK);
    chk("R1", "ie", ie, 0);
    chk("R1", "ir", ir, 0);
    chk("R1", "strobes", {mem_rd, mem_wr}, 0);
    rst = 0;
    // fast memory, request high but disabled: R6 no entry
    irq_req = 1;
    repeat (40) @(negedge clk);
    chk("R6", "no write while disabled", wr_count, 0);
    // slower memory and execute, then a jump (R5)
    mem_lat = 3; exec_lat = 2;
    do_jump = 1;
    wait (do_jump == 0);
    wait_exec_rise();
    chk("R5", "ir after jump", ir, prog(8'h40));
    chk("R4", "pc after jump fetch", pc, 8'h41);
    // enable and take the interrupt (R7, R8, R9)
    pulse_ie();
    wait (wr_count == 1);
    wait_exec_rise();
    r = ret_q[0];
    chk("R8", "handler first ir", ir, prog(VEC));
    chk("R7", "saved pc in stack", mem[STK - 1], DW'(r));
    chk("R7", "sp after entry", sp, STK - 1);
    chk("R7", "ie cleared", ie, 0);
    // request still high, no re-entry (R6)
    mem_lat = 1; exec_lat = 0;
    repeat (60) @(negedge clk);
    chk("R6", "no re-entry", wr_count, 1);
    // second entry stacks below the first (R7, R9)
    pulse_ie();
    wait (wr_count == 2);
    wait_exec_rise();
    chk("R7", "second saved pc", mem[STK - 2], DW'(ret_q[1]));
    chk("R7", "sp after nesting", sp, STK - 2);
    chk("R8", "handler ir again", ir, prog(VEC));
    irq_req = 0;
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule